// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block is the request-handling core of an eight-input interrupt controller. It captures request lines either on rising edges or by level, filters them through a mask, and selects the highest-priority pending line. When that line outranks everything already being serviced, it raises an interrupt output. On an acknowledge pulse it returns an 8-bit vector, marks the line as in service and drops the request that won.

A register front end supplies the configuration: a 5-bit vector base, the trigger mode, the mask, the automatic end-of-interrupt enable and a map of the lines that lead to a cascaded controller. The returned vector joins the base with the 3-bit index of the winning line. In-service bits are cleared in one of two ways. With automatic end-of-interrupt enabled they are cleared as part of the acknowledge. Otherwise a separate end-of-interrupt pulse releases them.

Top module: `irqv_core`

## Requirements
- R1: The returned vector is the 5-bit base in bits 7:3 and the winning line index in bits 2:0. With base 5'h04, line 0 gives 8'h20 and line 7 gives 8'h27.
- R2: Among pending, unmasked lines, line 0 has the highest priority and line 7 the lowest.
- R3: A line whose mask bit is 1 never causes the interrupt output to rise. Its request stays latched and is served once the mask bit returns to 0.
- R4: When the level input is 0 (edge mode), a request is captured on a rising edge of the line. After acknowledge, a line that is held high makes no new request.
- R5: When the level input is 1 (level mode), a request exists only while the line is high. If the line drops before acknowledge, the interrupt output falls and an acknowledge returns no vector.
- R6: With automatic end-of-interrupt off, acknowledge sets the in-service bit of the winning line. An end-of-interrupt pulse clears the lowest-numbered in-service bit that is set.
- R7: With automatic end-of-interrupt on, acknowledge leaves the in-service bits unchanged.
- R8: A pending request raises the interrupt output only when its index is lower than every in-service bit that is set.
- R9: The cascade flag output is 1 together with the vector exactly when the acknowledged line's bit in the cascade map is 1.
- R10: An acknowledge accepted while the interrupt output is 1 produces a one-cycle vector-valid pulse in the following cycle. An acknowledge while the interrupt output is 0 produces no pulse.
- R11: After reset the interrupt output, vector valid and all in-service bits are 0.
- R12: In level mode a line still held high after an automatically ended acknowledge requests again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqLines | input | 8 | Interrupt request lines |
| cfgBase | input | 5 | Vector base bits |
| cfgLevel | input | 1 | 1 selects level mode, 0 selects edge mode |
| cfgMask | input | 8 | Per-line mask, 1 blocks the line |
| cfgAutoEoi | input | 1 | 1 clears in-service at acknowledge |
| cfgCascade | input | 8 | Lines that lead to a cascaded controller |
| intAck | input | 1 | Acknowledge pulse |
| eoiPulse | input | 1 | End-of-interrupt pulse |
| intOut | output | 1 | Interrupt output |
| vecValid | output | 1 | Vector valid pulse |
| vecOut | output | 8 | Returned vector |
| vecCascade | output | 1 | Acknowledged line leads to a cascaded controller |
| isrOut | output | 8 | In-service bits |

## Verification
Assertions check on every cycle that the interrupt output is backed by an unmasked pending line, that vector-valid only follows an accepted acknowledge, that an end-of-interrupt pulse removes exactly one in-service bit, and that an acknowledge with automatic end-of-interrupt leaves the in-service bits untouched. Several behaviours can only be shown by the bench's scenarios: the vector value for a given base and winner, nesting against in-service lines, edge re-arming compared with level re-requesting, a request that is withdrawn before acknowledge, and a masked request that is served after it is unmasked.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int LINE_CNT = 8;
  localparam int IDX_W    = $clog2(LINE_CNT);
  localparam int VEC_W    = 8;
  localparam int BASE_W   = VEC_W - IDX_W;

  typedef struct packed {
    logic             ackTake;
    logic [IDX_W-1:0] ackIdx;
    logic             eoiTake;
    logic [IDX_W-1:0] eoiIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_CNT-1:0] pendIn,
  input  logic [LINE_CNT-1:0] isrIn,
  input  logic [LINE_CNT-1:0] cfgMask,
  input  logic                intAck,
  input  logic                eoiPulse,
  output ctrlStrobes_t        strb,
  output logic                intOut
);
  logic [LINE_CNT-1:0] eligible;
  logic                winHit, isrHit;
  logic [IDX_W-1:0]    winIdx, isrIdx;

  // per-line gating of pending requests by the mask
  for (genvar g = 0; g < LINE_CNT; g++) begin : g_gate
    assign eligible[g] = pendIn[g] & ~cfgMask[g];
  end

  // fixed priority: scan downward so the lowest index wins
  always_comb begin
    winHit = 1'b0;
    winIdx = '0;
    isrHit = 1'b0;
    isrIdx = '0;
    for (int i = LINE_CNT - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winHit = 1'b1;
        winIdx = IDX_W'(i);
      end
      if (isrIn[i]) begin
        isrHit = 1'b1;
        isrIdx = IDX_W'(i);
      end
    end
  end

  assign intOut       = winHit && (!isrHit || (winIdx < isrIdx));
  assign strb.ackTake = intAck && intOut;
  assign strb.ackIdx  = winIdx;
  assign strb.eoiTake = eoiPulse && isrHit;
  assign strb.eoiIdx  = isrIdx;

  // R3: interrupt only when some unmasked line is pending
  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> ((pendIn & ~cfgMask) != '0));

  // R8: the acknowledged line is never already in service
  a_r8_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ackTake |-> !isrIn[strb.ackIdx]);
endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_CNT-1:0] reqLines,
  input  logic [BASE_W-1:0]   cfgBase,
  input  logic                cfgLevel,
  input  logic                cfgAutoEoi,
  input  logic [LINE_CNT-1:0] cfgCascade,
  input  ctrlStrobes_t        strb,
  output logic [LINE_CNT-1:0] pendOut,
  output logic [LINE_CNT-1:0] isrOut,
  output logic                vecValid,
  output logic [VEC_W-1:0]    vecOut,
  output logic                vecCascade
);
  logic [LINE_CNT-1:0] reqPrev, rise, ackOh, eoiOh, setOh;
  logic [LINE_CNT-1:0] irr, isr, irrNext, isrNext;

  assign rise  = reqLines & ~reqPrev;
  assign ackOh = strb.ackTake ? (LINE_CNT'(1) << strb.ackIdx) : '0;
  assign eoiOh = strb.eoiTake ? (LINE_CNT'(1) << strb.eoiIdx) : '0;
  assign setOh = cfgAutoEoi ? '0 : ackOh;

  always_comb begin
    if (cfgLevel) irrNext = reqLines & ~ackOh;
    else          irrNext = (irr | rise) & ~ackOh;
    isrNext = (isr & ~eoiOh) | setOh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqPrev    <= '0;
      irr        <= '0;
      isr        <= '0;
      vecValid   <= 1'b0;
      vecOut     <= '0;
      vecCascade <= 1'b0;
    end else begin
      reqPrev    <= reqLines;
      irr        <= irrNext;
      isr        <= isrNext;
      vecValid   <= strb.ackTake;
      vecCascade <= strb.ackTake && cfgCascade[strb.ackIdx];
      if (strb.ackTake) vecOut <= {cfgBase, strb.ackIdx};
    end
  end

  assign pendOut = irr;
  assign isrOut  = isr;

  // R10: a vector only follows an accepted acknowledge
  a_r10_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> $past(strb.ackTake));

  // R6: end-of-interrupt without acknowledge removes exactly one bit
  a_r6_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.eoiTake && !strb.ackTake) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R7: automatic end-of-interrupt leaves in-service bits alone
  a_r7_auto_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ackTake && cfgAutoEoi && !strb.eoiTake) |=> $stable(isr));

  // R9: cascade flag only travels with a valid vector
  a_r9_cascade_with_vec: assert property (@(posedge clk) disable iff (!rst_n)
    vecCascade |-> vecValid);
endmodule

// File: rtl/irqv_core.sv
module irqv_core
  import irqv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_CNT-1:0] reqLines,
  input  logic [BASE_W-1:0]   cfgBase,
  input  logic                cfgLevel,
  input  logic [LINE_CNT-1:0] cfgMask,
  input  logic                cfgAutoEoi,
  input  logic [LINE_CNT-1:0] cfgCascade,
  input  logic                intAck,
  input  logic                eoiPulse,
  output logic                intOut,
  output logic                vecValid,
  output logic [VEC_W-1:0]    vecOut,
  output logic                vecCascade,
  output logic [LINE_CNT-1:0] isrOut
);
  ctrlStrobes_t        strb;
  logic [LINE_CNT-1:0] pendWire;

  irqv_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pendIn   (pendWire),
    .isrIn    (isrOut),
    .cfgMask  (cfgMask),
    .intAck   (intAck),
    .eoiPulse (eoiPulse),
    .strb     (strb),
    .intOut   (intOut)
  );

  irqv_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqLines   (reqLines),
    .cfgBase    (cfgBase),
    .cfgLevel   (cfgLevel),
    .cfgAutoEoi (cfgAutoEoi),
    .cfgCascade (cfgCascade),
    .strb       (strb),
    .pendOut    (pendWire),
    .isrOut     (isrOut),
    .vecValid   (vecValid),
    .vecOut     (vecOut),
    .vecCascade (vecCascade)
  );
endmodule

// File: tb/irqv_core_bench.sv
module irqv_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqLines = '0;
  logic [4:0] cfgBase = 5'h04;
  logic       cfgLevel = 1'b0;
  logic [7:0] cfgMask = '0;
  logic       cfgAutoEoi = 1'b0;
  logic [7:0] cfgCascade = 8'h04;
  logic       intAck = 1'b0;
  logic       eoiPulse = 1'b0;
  logic       intOut, vecValid, vecCascade;
  logic [7:0] vecOut, isrOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irqv_core u_irqv_core (
    .clk(clk), .rst_n(rst_n), .reqLines(reqLines), .cfgBase(cfgBase),
    .cfgLevel(cfgLevel), .cfgMask(cfgMask), .cfgAutoEoi(cfgAutoEoi),
    .cfgCascade(cfgCascade), .intAck(intAck), .eoiPulse(eoiPulse),
    .intOut(intOut), .vecValid(vecValid), .vecOut(vecOut),
    .vecCascade(vecCascade), .isrOut(isrOut)
  );

  typedef struct packed {
    logic       lvl;
    logic       autoE;
    logic [7:0] mask;
    logic [4:0] base;
    logic [7:0] lines;
    logic       expInt;
    logic [7:0] expVec;
    logic       expCas;
    logic [7:0] expIsr;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 1'b0, 8'h00, 5'h04, 8'h01, 1'b1, 8'h20, 1'b0, 8'h01},
    '{1'b0, 1'b0, 8'h00, 5'h04, 8'h80, 1'b1, 8'h27, 1'b0, 8'h80},
    '{1'b0, 1'b0, 8'h00, 5'h04, 8'h0C, 1'b1, 8'h22, 1'b1, 8'h04},
    '{1'b0, 1'b0, 8'h04, 5'h04, 8'h0C, 1'b1, 8'h23, 1'b0, 8'h08},
    '{1'b0, 1'b0, 8'hFF, 5'h04, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'h00, 5'h1F, 8'h40, 1'b1, 8'hFE, 1'b0, 8'h40},
    '{1'b0, 1'b1, 8'h00, 5'h01, 8'h10, 1'b1, 8'h0C, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'h7F, 5'h10, 8'h80, 1'b1, 8'h87, 1'b0, 8'h80}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; reqLines = '0; intAck = 1'b0; eoiPulse = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulseAck();
    intAck = 1'b1; tick(); intAck = 1'b0;
  endtask

  task automatic pulseEoi();
    eoiPulse = 1'b1; tick(); eoiPulse = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    chk("R11 intOut after reset", {7'd0, intOut}, 8'h00);
    chk("R11 vecValid after reset", {7'd0, vecValid}, 8'h00);
    chk("R11 isr after reset", isrOut, 8'h00);

    // table walk: R1 R2 R3 R6 R7 R9 R10
    for (int k = 0; k < 8; k++) begin
      cfgLevel = TBL[k].lvl; cfgAutoEoi = TBL[k].autoE;
      cfgMask = TBL[k].mask; cfgBase = TBL[k].base;
      doReset();
      reqLines = TBL[k].lines; tick();
      chk($sformatf("R2/R3 intOut row %0d", k), {7'd0, intOut}, {7'd0, TBL[k].expInt});
      pulseAck();
      chk($sformatf("R10 vecValid row %0d", k), {7'd0, vecValid}, {7'd0, TBL[k].expInt});
      if (TBL[k].expInt) begin
        chk($sformatf("R1 vector row %0d", k), vecOut, TBL[k].expVec);
        chk($sformatf("R9 cascade row %0d", k), {7'd0, vecCascade}, {7'd0, TBL[k].expCas});
      end
      chk($sformatf("R6/R7 isr row %0d", k), isrOut, TBL[k].expIsr);
      tick();
      chk($sformatf("R10 single pulse row %0d", k), {7'd0, vecValid}, 8'h00);
    end

    // R8 nesting and R6 end-of-interrupt order
    cfgLevel = 1'b0; cfgAutoEoi = 1'b0; cfgMask = '0; cfgBase = 5'h04;
    doReset();
    reqLines = 8'h08; tick();
    pulseAck();
    chk("R6 isr set line 3", isrOut, 8'h08);
    reqLines = 8'h28; tick();
    chk("R8 lower line blocked", {7'd0, intOut}, 8'h00);
    reqLines = 8'h2A; tick();
    chk("R8 higher line nests", {7'd0, intOut}, 8'h01);
    pulseAck();
    chk("R1 nested vector", vecOut, 8'h21);
    chk("R6 nested isr", isrOut, 8'h0A);
    pulseEoi();
    chk("R6 eoi clears line 1 first", isrOut, 8'h08);
    chk("R8 line 5 still blocked", {7'd0, intOut}, 8'h00);
    pulseEoi();
    chk("R6 eoi clears line 3", isrOut, 8'h00);
    chk("R8 line 5 now served", {7'd0, intOut}, 8'h01);

    // R4 edge mode held line does not re-request
    cfgLevel = 1'b0; cfgAutoEoi = 1'b1;
    doReset();
    reqLines = 8'h02; tick();
    pulseAck();
    tick();
    chk("R4 held line no new request", {7'd0, intOut}, 8'h00);
    reqLines = 8'h00; tick();
    reqLines = 8'h02; tick();
    chk("R4 new edge requests", {7'd0, intOut}, 8'h01);

    // R12 level mode re-requests
    cfgLevel = 1'b1;
    doReset();
    reqLines = 8'h02; tick();
    pulseAck();
    tick();
    chk("R12 level line requests again", {7'd0, intOut}, 8'h01);

    // R5 withdrawn request
    cfgAutoEoi = 1'b0;
    doReset();
    reqLines = 8'h10; tick();
    chk("R5 level request seen", {7'd0, intOut}, 8'h01);
    reqLines = 8'h00; tick();
    chk("R5 intOut drops", {7'd0, intOut}, 8'h00);
    pulseAck();
    chk("R5 no vector after drop", {7'd0, vecValid}, 8'h00);
    chk("R5 no isr after drop", isrOut, 8'h00);

    // R3 masked request stays latched
    cfgLevel = 1'b0; cfgMask = 8'h02;
    doReset();
    reqLines = 8'h02; tick();
    reqLines = 8'h00; tick();
    chk("R3 masked line silent", {7'd0, intOut}, 8'h00);
    cfgMask = 8'h00; #1;
    chk("R3 unmasked latched request", {7'd0, intOut}, 8'h01);
    pulseAck();
    chk("R3 latched vector", vecOut, 8'h21);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule